// File: doc/BRIEF.md
# Column-Summed Binary Multiplier

This block multiplies two unsigned N-bit operands (N is 8 by default) and returns the full 2N-bit product. It does not add whole shifted rows of partial products. It forms the result one output column at a time. For column k it ANDs every operand bit pair whose indices add up to k. It then counts those one-bit products together with a multi-bit carry from column k-1. The lowest bit of that column total is product bit k, and the remaining bits become the carry into column k+1.

Every AND term of every column is formed at once in one combinational cloud. Only the carry ripples from column to column. The caller presents operands with a one-cycle strobe. The block registers the result once and raises its own strobe on the following cycle. It accepts a new pair on every cycle.

Top module: `vcm_mult`

## Requirements
- R1: Product bit 0 equals op_a[0] AND op_b[0] for the captured pair.
- R2: Product bit 1 equals (op_a[0] AND op_b[1]) XOR (op_a[1] AND op_b[0]) for the captured pair.
- R3: For every pair of N-bit operands, product equals op_a × op_b as unsigned integers. For N=8 this holds over all 65536 pairs, including 154 × 142 = 21868.
- R4: The carry into the lowest column is zero, so a zero operand gives a zero product, and 1 × 1 gives exactly 1.
- R5: The upper product bits carry the final column carry correctly at the top of the range. For N=8, 255 × 255 = 65025 and 128 × 128 = 16384.
- R6: out_valid is high exactly one clock after a cycle with in_valid high, and low one clock after a cycle with in_valid low.
- R7: While in_valid is low, product keeps its last value, whatever the operands do.
- R8: A synchronous active-high rst drives out_valid and product to zero on the next clock. rst wins over an in_valid in the same cycle.
- R9: Operand pairs presented on consecutive cycles each produce their own product on the next cycle, so one result is delivered per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand strobe; the pair is captured on this clock |
| op_a | input | N | Multiplicand, unsigned |
| op_b | input | N | Multiplier, unsigned |
| out_valid | output | 1 | Product strobe, one clock after in_valid |
| product | output | 2N | Registered unsigned product |

## Verification
Reset and operand capture can land on the same clock edge. The bench provokes this by holding rst high while in_valid is high with the largest operands. It then expects out_valid low and a zero product on the next cycle, rather than 65025. Capture and hold also meet whenever the strobe drops while the operands keep changing. That case is judged by checking that the previous product stays unchanged at the port.

// File: rtl/vcm_pkg.sv
package vcm_pkg;

    // Width of the carry passed between columns.
    // A column adds at most n product bits to an incoming carry that is
    // itself bounded by n, so the carry never exceeds n.
    function automatic int unsigned carry_width(input int unsigned n);
        return $clog2(n + 1);
    endfunction

endpackage

// File: rtl/vcm_ppgen.sv
module vcm_ppgen #(
    parameter int unsigned N = 8
) (
    input  logic [N-1:0]               op_a,
    input  logic [N-1:0]               op_b,
    output logic [2*N-2:0][N-1:0]      cols
);
    localparam int NCOL = 2 * N - 1;

    // Slot k of column c holds op_a[k] & op_b[c-k]; slots outside the grid are zero.
    for (genvar c = 0; c < NCOL; c++) begin : g_col
        for (genvar k = 0; k < N; k++) begin : g_slot
            localparam int J = c - k;
            if (J >= 0 && J < N) begin : g_and
                assign cols[c][k] = op_a[k] & op_b[J];
            end else begin : g_zero
                assign cols[c][k] = 1'b0;
            end
        end
    end
endmodule

// File: rtl/vcm_col.sv
module vcm_col #(
    parameter int unsigned N  = 8,
    parameter int unsigned CW = 4
) (
    input  logic [N-1:0]  pp,
    input  logic [CW-1:0] cin,
    output logic          bit_o,
    output logic [CW-1:0] cout
);
    localparam int SW = CW + 1;

    logic [SW-1:0] sum;

    always_comb begin
        sum = SW'(cin);
        for (int k = 0; k < N; k++) begin
            sum = sum + SW'(pp[k]);
        end
    end

    assign bit_o = sum[0];
    assign cout  = sum[SW-1:1];
endmodule

// File: rtl/vcm_mult.sv
module vcm_mult #(
    parameter int unsigned N = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [N-1:0]     op_a,
    input  logic [N-1:0]     op_b,
    output logic             out_valid,
    output logic [2*N-1:0]   product
);
    localparam int PW   = 2 * N;
    localparam int NCOL = 2 * N - 1;
    localparam int CW   = vcm_pkg::carry_width(N);

    typedef struct packed {
        logic          vld;
        logic [PW-1:0] prod;
    } out_t;

    logic [NCOL-1:0][N-1:0] cols;
    logic [NCOL:0][CW-1:0]  carry;
    logic [PW-1:0]          prod_c;
    out_t                   st_d, st_q;

    vcm_ppgen #(.N(N)) i_ppgen (
        .op_a (op_a),
        .op_b (op_b),
        .cols (cols)
    );

    assign carry[0] = '0;

    for (genvar c = 0; c < NCOL; c++) begin : g_chain
        vcm_col #(.N(N), .CW(CW)) i_col (
            .pp    (cols[c]),
            .cin   (carry[c]),
            .bit_o (prod_c[c]),
            .cout  (carry[c+1])
        );
    end

    // The final carry is at most one; any of its bits represents it.
    assign prod_c[PW-1] = |carry[NCOL];

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.prod = prod_c;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign product   = st_q.prod;
endmodule

// File: rtl/vcm_mult_chk.sv
module vcm_mult_chk #(
    parameter int unsigned N = 8
) (
    input logic           clk,
    input logic           rst,
    input logic           in_valid,
    input logic [N-1:0]   op_a,
    input logic [N-1:0]   op_b,
    input logic           out_valid,
    input logic [2*N-1:0] product
);
    AST_BIT0_VERTICAL: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> product[0] == $past(op_a[0] & op_b[0])); // R1

    AST_BIT1_CROSS: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> product[1] == $past((op_a[0] & op_b[1]) ^ (op_a[1] & op_b[0]))); // R2

    AST_FULL_PRODUCT: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> product == ($past({{N{1'b0}}, op_a}) * $past({{N{1'b0}}, op_b}))); // R3

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid); // R6

    AST_VALID_DROPS: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid); // R6

    AST_HOLD_PRODUCT: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(product)); // R7

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (!out_valid && product == '0)); // R8
endmodule

bind vcm_mult vcm_mult_chk #(.N(N)) i_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .op_a      (op_a),
    .op_b      (op_b),
    .out_valid (out_valid),
    .product   (product)
);

// File: tb/test_vcm_mult.sv
module test_vcm_mult;
    localparam int  N     = 8;
    localparam time CLK_P = 10ns;
    localparam int  NVEC  = 12;

    // {op_a, op_b, expected product}
    localparam logic [31:0] VEC [NVEC] = '{
        {8'd154, 8'd142, 16'd21868},
        {8'd1,   8'd1,   16'd1},
        {8'd0,   8'd255, 16'd0},
        {8'd255, 8'd0,   16'd0},
        {8'd255, 8'd255, 16'd65025},
        {8'd128, 8'd128, 16'd16384},
        {8'd2,   8'd1,   16'd2},
        {8'd1,   8'd2,   16'd2},
        {8'd3,   8'd3,   16'd9},
        {8'd97,  8'd94,  16'd9118},
        {8'd58,  8'd48,  16'd2784},
        {8'd170, 8'd85,  16'd14450}
    };

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           in_valid = 1'b0;
    logic [N-1:0]   op_a = '0;
    logic [N-1:0]   op_b = '0;
    logic           out_valid;
    logic [2*N-1:0] product;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_P / 2) clk = ~clk;

    vcm_mult #(.N(N)) i_vcm_mult (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .op_a      (op_a),
        .op_b      (op_b),
        .out_valid (out_valid),
        .product   (product)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (a=%0d b=%0d)", req, act, exp, op_a, op_b);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(CLK_P * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // Reset state (R8)
        repeat (3) @(negedge clk);
        chk("R8 reset out_valid", 32'(out_valid), 0);
        chk("R8 reset product", 32'(product), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R6 idle out_valid", 32'(out_valid), 0);

        // Table walk (R1..R5), back to back (R9)
        for (int i = 0; i < NVEC; i++) begin
            op_a     = VEC[i][31:24];
            op_b     = VEC[i][23:16];
            in_valid = 1'b1;
            @(negedge clk);
            chk("R3 table product", 32'(product), 32'(VEC[i][15:0]));
            chk("R6 table out_valid", 32'(out_valid), 1);
        end

        // Hold while strobe low (R7, R6)
        op_a = 8'd154; op_b = 8'd142; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0; op_a = 8'd7; op_b = 8'd9;
        @(negedge clk);
        chk("R7 hold product", 32'(product), 21868);
        chk("R6 drop out_valid", 32'(out_valid), 0);
        op_a = 8'd200;
        @(negedge clk);
        chk("R7 hold product again", 32'(product), 21868);

        // Reset together with capture (R8)
        op_a = 8'd255; op_b = 8'd255; in_valid = 1'b1; rst = 1'b1;
        @(negedge clk);
        chk("R8 reset beats valid out_valid", 32'(out_valid), 0);
        chk("R8 reset beats valid product", 32'(product), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R5 top after reset", 32'(product), 65025);

        // Exhaustive sweep, one pair per clock (R1, R2, R3, R4, R9)
        for (int a = 0; a < 256; a++) begin
            for (int b = 0; b < 256; b++) begin
                op_a = 8'(a); op_b = 8'(b); in_valid = 1'b1;
                @(negedge clk);
                if (product !== 16'(a * b)) begin
                    chk("R3 sweep product", 32'(product), 32'(a * b));
                end else if (product[0] !== (op_a[0] & op_b[0])) begin
                    chk("R1 bit0", 32'(product[0]), 32'(op_a[0] & op_b[0]));
                end else if (product[1] !== ((op_a[0] & op_b[1]) ^ (op_a[1] & op_b[0]))) begin
                    chk("R2 bit1", 32'(product[1]), 32'((op_a[0] & op_b[1]) ^ (op_a[1] & op_b[0])));
                end else begin
                    chk("R9 sweep valid", 32'(out_valid), 1);
                end
            end
        end
        in_valid = 1'b0;
        @(negedge clk);
        chk("R4 zero-operand last row sanity", 32'(out_valid), 0);

        finish_run();
    end
endmodule